// File: doc/BRIEF.md
# Preloadable Digital Watchdog Timer

The block is a watchdog timer built around a 25-bit down counter. A 12-bit timeout value sits in a software-visible register. When software services the watchdog with a one-cycle pulse, that value is placed in the top bits of the counter and the low bits are filled with ones. The counter then runs down. If it passes zero before the next service, a one-cycle expiry pulse goes to the reset logic. After that the block stays expired until it is reset.

Software reaches the block through a small register port with two addresses. Address 0 holds the timeout value and address 1 holds the run control. Every write carries a privilege flag, and unprivileged writes have no effect. Reads work at any privilege level.

A parameter selects one of two variants:
- **Always-on variant:** the counter starts from a fixed start value as soon as reset is released. The timeout value may be changed until expiry.
- **Software-start variant:** the counter is idle until software sets the run bit. Setting the run bit loads the counter from the timeout value. From then on the timeout value is frozen.

Top module: `wdog_core`

## Requirements
- R1: After reset, address 0 reads 0x00000FFF. Address 0 always reads the timeout value in bits 11:0, with bits 31:12 reading zero. Data bits 31:12 of a write are discarded.
- R2: Reads return register contents whatever the privilege flag. A write (to address 0 or address 1) has effect only when `bus_priv` is 1.
- R3: In the always-on variant, the counter holds `START_VAL` (default 0x2DFFFF) during reset and decrements on every clock once reset is low. `expire` is therefore high in the cycle after the `START_VAL`+1-th rising edge with reset low.
- R4: A service pulse sampled at a clock edge while the counter is non-zero loads the counter with {timeout value, 13 ones}. `expire` then rises after exactly (timeout value + 1) × 8192 further edges, counted from the service edge. A service sampled while the count is 1 still rescues the watchdog.
- R5: `expire` is high for exactly one cycle. Afterwards the counter stays at zero and every later service is ignored, so no further expiry pulse appears until reset.
- R6: A service pulse sampled at the edge where the count is already zero is ignored. The expiry happens at that edge anyway.
- R7: In the software-start variant, the counter does nothing and services are ignored until a privileged write to address 1 with bit 0 set. That edge loads {timeout value, 13 ones}, and `expire` rises (timeout value + 1) × 8192 edges later.
- R8: In the software-start variant, the run bit reads back at bit 0 of address 1 (reset value 0). Once set, it can be cleared only by reset, and writes to address 0 are ignored.
- R9: In the always-on variant, address 1 reads 0x00000001. Privileged writes to address 0 take effect while the counter runs and are ignored after expiry.
- R10: `bus_rdata` is registered: it shows the addressed register one cycle after the address is presented. Addresses 2 and 3 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_priv | input | 1 | Privilege flag qualifying writes |
| bus_addr | input | 2 | Register address (0 timeout value, 1 run control) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| service | input | 1 | One-cycle watchdog service pulse |
| expire | output | 1 | One-cycle expiry pulse |

## Verification
The bench measures the exact edge count to expiry from three starting points: reset release, a service pulse and a run-bit write. A fill pattern of zeros instead of ones, or an off-by-one at zero, would show up as an expiry 8191 cycles early or one cycle late.

It places a service at the count of one, which must rescue the watchdog, and at the count of zero, which must not. A wrong priority there either misses the expiry or extends it by a whole period.

After expiry it services and writes again and waits a full period. A design whose expired state is not sticky would fire a second pulse or accept the new timeout value.

In the software-start variant it checks three things: an early service is ignored, the run bit cannot be cleared, and writes to the frozen timeout value do not take effect. A design missing any of these would start early, fail to keep running, or change its timeout under way.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned WDOG_ADDR_W = 2;

  typedef enum logic [WDOG_ADDR_W-1:0] {
    REG_TIMEOUT = 2'd0,
    REG_RUN     = 2'd1,
    REG_SPARE2  = 2'd2,
    REG_SPARE3  = 2'd3
  } wdog_reg_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned PRE_W     = 12,
  parameter int unsigned DATA_W    = 32,
  parameter bit          ALWAYS_ON = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  logic                   priv,
  input  logic [WDOG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   fired,
  output logic [PRE_W-1:0]       preload,
  output logic                   run,
  output logic                   start,
  output logic [DATA_W-1:0]      rdata
);
  localparam int unsigned PAD_W = DATA_W - PRE_W;

  logic pre_lock;
  logic pre_we;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[DATA_W-1:PRE_W], fired};

  generate
    if (ALWAYS_ON) begin : g_always_on
      assign run      = 1'b1;
      assign start    = 1'b0;
      assign pre_lock = fired;
    end else begin : g_sw_start
      logic run_q;
      assign start    = wr && priv && (addr == REG_RUN) && wdata[0] && !run_q;
      assign run      = run_q;
      assign pre_lock = run_q;

      always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else if (start) run_q <= 1'b1;
      end

      // R8: the run bit, once set, survives until reset
      a_r8_run_sticky: assert property (@(posedge clk) disable iff (rst)
        run_q |=> run_q);
    end
  endgenerate

  assign pre_we = wr && priv && (addr == REG_TIMEOUT) && !pre_lock;

  always_ff @(posedge clk) begin
    if (rst) preload <= '1;
    else if (pre_we) preload <= wdata[PRE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      unique case (addr)
        REG_TIMEOUT: rdata <= {{PAD_W{1'b0}}, preload};
        REG_RUN:     rdata <= {{(DATA_W-1){1'b0}}, run};
        default:     rdata <= '0;
      endcase
    end
  end

  // R2: no write without privilege
  a_r2_priv_gate: assert property (@(posedge clk) disable iff (rst)
    (!priv) |=> $stable(preload));

  // R8 / R9: a locked timeout value does not move
  a_r8_locked_preload: assert property (@(posedge clk) disable iff (rst)
    pre_lock |=> $stable(preload));

  // R1: upper read bits of the timeout register stay zero
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == REG_TIMEOUT) |=> (rdata[DATA_W-1:PRE_W] == '0));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned        CNT_W     = 25,
  parameter int unsigned        PRE_W     = 12,
  parameter logic [CNT_W-1:0]   START_VAL = 25'h2DFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             start,
  input  logic             svc,
  input  logic [PRE_W-1:0] preload,
  output logic             expire,
  output logic             fired
);
  localparam int unsigned FILL_W = CNT_W - PRE_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;
  logic             at_zero;

  assign reload  = {preload, {FILL_W{1'b1}}};
  assign at_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= START_VAL;
      fired  <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (start) begin
        cnt <= reload;
      end else if (active && !fired) begin
        if (at_zero) begin
          fired  <= 1'b1;
          expire <= 1'b1;
        end else if (svc) begin
          cnt <= reload;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R5: expiry is a single-cycle pulse
  a_r5_pulse_width: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);

  // R5: after expiry the counter rests at zero and stays expired
  a_r5_hold_zero: assert property (@(posedge clk) disable iff (rst)
    fired |=> (fired && at_zero));

  // R4: a service on a non-zero count reloads from the timeout value
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (active && !fired && !start && svc && !at_zero) |=> (cnt == $past(reload)));

  // R3: an unserviced running counter steps down by one
  a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
    (active && !fired && !start && !svc && !at_zero) |=> (cnt == $past(cnt) - 1'b1));

  // R6: reaching zero always fires, service or not
  a_r6_zero_fires: assert property (@(posedge clk) disable iff (rst)
    (active && !fired && !start && at_zero) |=> expire);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned      CNT_W     = 25,
  parameter int unsigned      PRE_W     = 12,
  parameter int unsigned      DATA_W    = 32,
  parameter bit               ALWAYS_ON = 1'b1,
  parameter logic [CNT_W-1:0] START_VAL = 25'h2DFFFF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_priv,
  input  logic [WDOG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic                   service,
  output logic                   expire
);
  logic [PRE_W-1:0] preload;
  logic             run;
  logic             start;
  logic             fired;

  wdog_regs #(
    .PRE_W     (PRE_W),
    .DATA_W    (DATA_W),
    .ALWAYS_ON (ALWAYS_ON)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (bus_wr),
    .priv    (bus_priv),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .fired   (fired),
    .preload (preload),
    .run     (run),
    .start   (start),
    .rdata   (bus_rdata)
  );

  wdog_counter #(
    .CNT_W     (CNT_W),
    .PRE_W     (PRE_W),
    .START_VAL (START_VAL)
  ) u_counter (
    .clk     (clk),
    .rst     (rst),
    .active  (run),
    .start   (start),
    .svc     (service),
    .preload (preload),
    .expire  (expire),
    .fired   (fired)
  );
endmodule

// File: tb/wdog_core_test.sv
module wdog_core_test;
  localparam logic [24:0] START = 25'h005FFF;
  localparam int unsigned PERIOD = 8192;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0, priv = 1'b0, svc = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] ao_rdata, sw_rdata;
  logic        ao_exp, sw_exp;
  int unsigned cyc = 0;
  int          pass_n = 0;
  int          fail_n = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_core #(.ALWAYS_ON(1'b1), .START_VAL(START)) uut (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_priv(priv), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(ao_rdata), .service(svc), .expire(ao_exp));

  wdog_core #(.ALWAYS_ON(1'b0), .START_VAL(START)) uut_sw (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_priv(priv), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(sw_rdata), .service(svc), .expire(sw_exp));

  function automatic int unsigned timeout_of(input int unsigned p);
    return (p + 1) * PERIOD;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act === exp) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr = 1'b0; svc = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d, input logic p);
    wr = 1'b1; addr = a; wdata = d; priv = p;
    @(posedge clk); @(negedge clk);
    wr = 1'b0; priv = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] ao, output logic [31:0] sw);
    wr = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    ao = ao_rdata; sw = sw_rdata;
  endtask

  task automatic do_service(output int unsigned t0);
    svc = 1'b1;
    @(posedge clk); @(negedge clk);
    svc = 1'b0;
    t0 = cyc;
  endtask

  task automatic wait_exp(input bit sel_sw, input int unsigned limit, output int unsigned t);
    t = 0;
    for (int unsigned i = 0; i < limit; i++) begin
      @(negedge clk);
      if ((sel_sw ? sw_exp : ao_exp) === 1'b1) begin
        t = cyc;
        break;
      end
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fail_n++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    logic [31:0] ra, rs;
    logic [11:0] model;
    int unsigned t0, t1, t;
    void'($urandom(32'd20240611));

    // reset state
    do_reset();
    reg_read(2'd0, ra, rs);
    chk("R1 reset timeout ao", ra, 32'h0000_0FFF);
    chk("R1 reset timeout sw", rs, 32'h0000_0FFF);
    reg_read(2'd1, ra, rs);
    chk("R9 run reads one", ra, 32'h1);
    chk("R8 run resets zero", rs, 32'h0);
    reg_read(2'd2, ra, rs);
    chk("R10 spare addr 2", ra, 32'h0);
    reg_read(2'd3, ra, rs);
    chk("R10 spare addr 3", rs, 32'h0);

    // privilege and upper bits
    reg_write(2'd0, 32'h0000_0123, 1'b0);
    reg_read(2'd0, ra, rs);
    chk("R2 unprivileged write ignored", ra, 32'h0000_0FFF);
    reg_write(2'd0, 32'hABCD_E456, 1'b1);
    reg_read(2'd0, ra, rs);
    chk("R1 upper write bits dropped", ra, 32'h0000_0456);
    model = 12'h456;
    for (int i = 0; i < 12; i++) begin
      logic [31:0] d;
      logic        p;
      d = $urandom;
      p = 1'($urandom % 2);
      reg_write(2'd0, d, p);
      if (p) model = d[11:0];
      reg_read(2'd0, ra, rs);
      chk("R2 random write", ra, {20'h0, model});
      chk("R2 random write sw", rs, {20'h0, model});
    end

    // R3: start value counts from reset release
    do_reset();
    t0 = cyc;
    wait_exp(1'b0, START + 20, t);
    chk("R3 expiry from reset", t - t0, START + 1);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'h0, ao_exp}, 32'h0);

    // R9 and R5: after expiry writes and services do nothing
    reg_write(2'd0, 32'h0, 1'b1);
    reg_read(2'd0, ra, rs);
    chk("R9 write after expiry ignored", ra, 32'h0000_0FFF);
    do_service(t0);
    wait_exp(1'b0, PERIOD + 200, t);
    chk("R5 no second expiry", t, 32'h0);

    // R4: directed service with timeout 0; R9 write while running
    do_reset();
    reg_write(2'd0, 32'h0, 1'b1);
    reg_read(2'd0, ra, rs);
    chk("R9 write while running", ra, 32'h0);
    do_service(t0);
    wait_exp(1'b0, PERIOD + 20, t);
    chk("R4 timeout zero", t - t0, timeout_of(0));

    // R4: service at count one rescues
    do_reset();
    reg_write(2'd0, 32'h0, 1'b1);
    do_service(t0);
    repeat (PERIOD - 2) @(negedge clk);
    do_service(t1);
    chk("R4 service at count one position", t1 - t0, PERIOD - 1);
    wait_exp(1'b0, PERIOD + 20, t);
    chk("R4 rescued at count one", t - t1, timeout_of(0));

    // R6: service at count zero loses to expiry
    do_reset();
    reg_write(2'd0, 32'h0, 1'b1);
    do_service(t0);
    repeat (PERIOD - 1) @(negedge clk);
    svc = 1'b1;
    @(negedge clk);
    svc = 1'b0;
    chk("R6 expiry wins over service", {31'h0, ao_exp}, 32'h1);
    chk("R6 expiry edge", cyc - t0, timeout_of(0));

    // R4: random timeout values and service spacing
    for (int k = 0; k < 2; k++) begin
      int unsigned p, r;
      p = $urandom % 2;
      r = ($urandom % 1500) + 1;
      do_reset();
      reg_write(2'd0, p, 1'b1);
      do_service(t0);
      repeat (r) @(negedge clk);
      do_service(t1);
      wait_exp(1'b0, timeout_of(p) + 20, t);
      chk("R4 random timeout", t - t1, timeout_of(p));
    end

    // R7 / R8: software-start variant
    do_reset();
    reg_write(2'd0, 32'h0, 1'b1);
    do_service(t0);
    wait_exp(1'b1, PERIOD + 200, t);
    chk("R7 idle before run bit", t, 32'h0);
    reg_write(2'd1, 32'h1, 1'b0);
    reg_read(2'd1, ra, rs);
    chk("R2 unprivileged run write ignored", rs, 32'h0);
    reg_write(2'd1, 32'h1, 1'b1);
    t0 = cyc;
    reg_write(2'd0, 32'h5, 1'b1);
    reg_read(2'd0, ra, rs);
    chk("R8 timeout frozen while running", rs, 32'h0);
    reg_write(2'd1, 32'h0, 1'b1);
    reg_read(2'd1, ra, rs);
    chk("R8 run bit sticky", rs, 32'h1);
    wait_exp(1'b1, PERIOD + 20, t);
    chk("R7 expiry after run bit", t - t0, timeout_of(0));
    @(negedge clk);
    chk("R5 sw pulse one cycle", {31'h0, sw_exp}, 32'h0);

    do_reset();
    reg_write(2'd0, 32'h1, 1'b1);
    reg_write(2'd1, 32'h1, 1'b1);
    t0 = cyc;
    wait_exp(1'b1, timeout_of(1) + 20, t);
    chk("R7 expiry timeout one", t - t0, timeout_of(1));

    report();
  end
endmodule